// File: doc/BRIEF.md
# Per-Channel Descriptor and Completion Ring Pair

This block sits between software and a transfer engine on one channel of a DMA controller. Software fills a four-slot descriptor ring through a narrow register window, and the engine drains it. The engine writes completion reports into a second four-slot ring, and software reads them back through the same kind of window. Each entry is 128 bits wide. It crosses the 32-bit register bus as four accesses in a row to one address, and an internal word counter steps through the four words.

Each ring exposes a packed status word. It carries both slot pointers, the full and empty flags, and a sticky error flag that is cleared by writing 1 to it. An operation that would overfill or underdrain a ring is dropped and sets that flag. A control write resets both rings to empty in one cycle.

The register map is as follows. Address 0 is control, and bit 0 resets the rings. Address 1 is the descriptor ring status. Address 2 is the report ring status. Address 3 is the descriptor write port. Address 4 is the report read port. Reads of any other address return 0.

Top module: `chan_ring_pair`

## Requirements
- R1: After reset, both status words read 0x100 (empty, both pointers 0, no error) and `desc_valid` is 0.
- R2: A status word puts the write slot in bits [1:0], the read slot in bits [5:4], empty in bit 8, full in bit 9 and error in bit 10; all other bits read 0.
- R3: A descriptor is four writes to address 3: address low, address high, byte length, flags. Word n lands in `desc_entry` bits [32n+31:32n]. The entry commits only on the fourth write, and `desc_valid` is 0 until then.
- R4: Each ring holds 4 entries. With equal pointers, the full or empty bit tells which case applies; otherwise occupancy is (write − read + 4) mod 4.
- R5: A committed descriptor arriving while its ring is full is dropped: the pointers and the head entry are unchanged and the error bit sets. Whether the ring is full is judged on the occupancy before that cycle.
- R6: A `desc_pop` pulse advances the descriptor read slot. A pop while the ring is empty changes nothing except that it sets the error bit.
- R7: `desc_notify` equals bit 16 of the head entry's flags word while `desc_valid` is 1.
- R8: `rpt_push` stores `rpt_entry`. Four reads of address 4 return count low, count high, spare word, flags, and the report read slot advances only on the fourth read.
- R9: A read of address 4 while the report ring is empty returns 0, moves nothing and sets the report error bit. An `rpt_push` into a full ring is dropped and sets that bit.
- R10: Writing a status word with bit 10 set clears that ring's error bit. Writing bit 10 as 0 leaves the error bit unchanged.
- R11: Writing 1 to bit 0 of control empties both rings, zeroes both pointers and both word counters, and leaves the error bits as they were.
- R12: Slot pointers wrap from 3 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects at the clock edge) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the read |
| desc_valid | output | 1 | Descriptor ring holds at least one entry |
| desc_entry | output | 128 | Head descriptor |
| desc_notify | output | 1 | Head descriptor asks for a completion report |
| desc_pop | input | 1 | Engine consumes the head descriptor |
| rpt_push | input | 1 | Engine stores a report |
| rpt_entry | input | 128 | Report to store |

## Verification
The hardest states to reach are the ones where a half-built entry coexists with a ring event. One case is a descriptor whose fourth word lands on a full ring. Another is a ring reset that arrives after only some words of an entry have been written. The stimulus fills the descriptor ring to four entries and then issues a complete fifth entry, and it checks that the head stays intact. It also writes two stray words, resets the rings, and then pushes a fresh descriptor whose exact contents show that the word counter restarted at zero. Underflow is provoked on both sides: an engine pop on an empty descriptor ring, and a software read of an empty report port.

// File: rtl/chan_ring_pkg.sv
package chan_ring_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_DSTAT = 3'd1,
    SEL_RSTAT = 3'd2,
    SEL_DPORT = 3'd3,
    SEL_RPORT = 3'd4
  } reg_sel_e;

  localparam int ST_RD_LSB    = 4;
  localparam int ST_EMPTY_BIT = 8;
  localparam int ST_FULL_BIT  = 9;
  localparam int ST_ERR_BIT   = 10;
  localparam int CTRL_CLR_BIT = 0;

  function automatic logic [31:0] status_word(input logic [1:0] wr_slot,
                                              input logic [1:0] rd_slot,
                                              input logic is_empty,
                                              input logic is_full,
                                              input logic has_err);
    logic [31:0] s;
    s = '0;
    s[1:0] = wr_slot;
    s[ST_RD_LSB +: 2] = rd_slot;
    s[ST_EMPTY_BIT] = is_empty;
    s[ST_FULL_BIT] = is_full;
    s[ST_ERR_BIT] = has_err;
    return s;
  endfunction
endpackage

// File: rtl/ring_core.sv
module ring_core #(
  parameter int W     = 128,
  parameter int DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     push,
  input  logic [W-1:0]             push_data,
  input  logic                     pop,
  input  logic                     err_clr,
  output logic [W-1:0]             head_data,
  output logic [$clog2(DEPTH)-1:0] wr_ptr,
  output logic [$clog2(DEPTH)-1:0] rd_ptr,
  output logic                     full,
  output logic                     empty,
  output logic                     err
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             err_q, err_d;
  logic             do_push, do_pop, mem_we;
  logic [W-1:0]     mem [DEPTH];

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);

  always_comb begin
    do_push = push && !full && !clr;
    do_pop  = pop && !empty && !clr;
    mem_we  = do_push;
    wr_d    = wr_q;
    rd_d    = rd_q;
    cnt_d   = cnt_q;
    err_d   = err_q;
    if (clr) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_d = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_d = cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
    if ((push && full) || (pop && empty)) err_d = 1'b1;
    else if (err_clr) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[wr_q] <= push_data;
  end

  assign head_data = mem[rd_q];
  assign wr_ptr    = wr_q;
  assign rd_ptr    = rd_q;
  assign err       = err_q;

  // R4
  full_ptr_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (wr_ptr == rd_ptr));
  // R4
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  // R5
  drop_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |=> ($stable(wr_ptr) && err));
  // R6
  pop_on_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !clr) |=> ($stable(rd_ptr) && err));
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_clr) |=> err);
  // R11
  clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (empty && wr_ptr == '0 && rd_ptr == '0));
endmodule

// File: rtl/word_packer.sv
module word_packer #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    stb,
  input  logic [WORD_W-1:0]       wdata,
  output logic                    commit,
  output logic [WORD_W*WORDS-1:0] entry
);
  localparam int CW = $clog2(WORDS);

  logic [CW-1:0]     cnt_q, cnt_d;
  logic [WORD_W-1:0] stage_q [WORDS-1];

  always_comb begin
    cnt_d = cnt_q;
    if (clr) cnt_d = '0;
    else if (stb) cnt_d = (cnt_q == CW'(WORDS - 1)) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < WORDS - 1; g++) begin : g_stage
    logic stage_en;
    assign stage_en = stb && !clr && (cnt_q == CW'(g));
    always_ff @(posedge clk) begin
      if (stage_en) stage_q[g] <= wdata;
    end
    assign entry[g*WORD_W +: WORD_W] = stage_q[g];
  end

  assign entry[(WORDS-1)*WORD_W +: WORD_W] = wdata;
  assign commit = stb && !clr && (cnt_q == CW'(WORDS - 1));

  // R3
  pk_commit_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
  // R11
  pk_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/word_unpacker.sv
module word_unpacker #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    stb,
  input  logic                    empty,
  input  logic [WORD_W*WORDS-1:0] head_data,
  output logic [WORD_W-1:0]       word,
  output logic                    pop_req
);
  localparam int CW = $clog2(WORDS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  assign last = (cnt_q == CW'(WORDS - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr) cnt_d = '0;
    else if (stb && !empty) cnt_d = last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign word    = empty ? '0 : head_data[cnt_q*WORD_W +: WORD_W];
  assign pop_req = stb && !clr && (empty || last);

  // R9
  up_empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && empty && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/chan_ring_pair.sv
module chan_ring_pair
  import chan_ring_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int DEPTH  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic                    reg_rd,
  input  logic [2:0]              reg_addr,
  input  logic [WORD_W-1:0]       reg_wdata,
  output logic [WORD_W-1:0]       reg_rdata,
  output logic                    desc_valid,
  output logic [WORD_W*WORDS-1:0] desc_entry,
  output logic                    desc_notify,
  input  logic                    desc_pop,
  input  logic                    rpt_push,
  input  logic [WORD_W*WORDS-1:0] rpt_entry
);
  localparam int ENTRY_W = WORD_W * WORDS;
  localparam int PTR_W   = $clog2(DEPTH);
  localparam int NOTE_BIT = (WORDS - 1) * WORD_W + 16;

  logic [1:0] rs_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  logic ring_clr, d_err_clr, r_err_clr, d_port_wr, r_port_rd;
  assign ring_clr  = reg_wr && (reg_addr == SEL_CTRL) && reg_wdata[CTRL_CLR_BIT];
  assign d_err_clr = reg_wr && (reg_addr == SEL_DSTAT) && reg_wdata[ST_ERR_BIT];
  assign r_err_clr = reg_wr && (reg_addr == SEL_RSTAT) && reg_wdata[ST_ERR_BIT];
  assign d_port_wr = reg_wr && (reg_addr == SEL_DPORT);
  assign r_port_rd = reg_rd && (reg_addr == SEL_RPORT);

  logic               d_commit;
  logic [ENTRY_W-1:0] d_staged;
  logic [PTR_W-1:0]   d_wr, d_rd, r_wr, r_rd;
  logic               d_full, d_empty, d_err, r_full, r_empty, r_err;
  logic [ENTRY_W-1:0] r_head;
  logic [WORD_W-1:0]  r_word;
  logic               r_pop;

  word_packer #(.WORD_W(WORD_W), .WORDS(WORDS)) desc_pack_i (
    .clk(clk), .rst_n(rst_sn), .clr(ring_clr), .stb(d_port_wr),
    .wdata(reg_wdata), .commit(d_commit), .entry(d_staged)
  );

  ring_core #(.W(ENTRY_W), .DEPTH(DEPTH)) desc_ring_i (
    .clk(clk), .rst_n(rst_sn), .clr(ring_clr), .push(d_commit),
    .push_data(d_staged), .pop(desc_pop), .err_clr(d_err_clr),
    .head_data(desc_entry), .wr_ptr(d_wr), .rd_ptr(d_rd),
    .full(d_full), .empty(d_empty), .err(d_err)
  );

  ring_core #(.W(ENTRY_W), .DEPTH(DEPTH)) rpt_ring_i (
    .clk(clk), .rst_n(rst_sn), .clr(ring_clr), .push(rpt_push),
    .push_data(rpt_entry), .pop(r_pop), .err_clr(r_err_clr),
    .head_data(r_head), .wr_ptr(r_wr), .rd_ptr(r_rd),
    .full(r_full), .empty(r_empty), .err(r_err)
  );

  word_unpacker #(.WORD_W(WORD_W), .WORDS(WORDS)) rpt_unpack_i (
    .clk(clk), .rst_n(rst_sn), .clr(ring_clr), .stb(r_port_rd),
    .empty(r_empty), .head_data(r_head), .word(r_word), .pop_req(r_pop)
  );

  assign desc_valid  = !d_empty;
  assign desc_notify = desc_valid && desc_entry[NOTE_BIT];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      SEL_DSTAT: reg_rdata = WORD_W'(status_word(2'(d_wr), 2'(d_rd), d_empty, d_full, d_err));
      SEL_RSTAT: reg_rdata = WORD_W'(status_word(2'(r_wr), 2'(r_rd), r_empty, r_full, r_err));
      SEL_RPORT: reg_rdata = r_word;
      default:   reg_rdata = '0;
    endcase
  end

  // R3
  valid_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (d_commit && !ring_clr && !desc_pop) |=> desc_valid);
  // R11
  clr_drops_valid_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    ring_clr |=> !desc_valid);
endmodule

// File: tb/chan_ring_pair_tb_top.sv
module chan_ring_pair_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         reg_wr, reg_rd, desc_pop, rpt_push;
  logic [2:0]   reg_addr;
  logic [31:0]  reg_wdata, reg_rdata;
  logic         desc_valid, desc_notify;
  logic [127:0] desc_entry, rpt_entry;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  chan_ring_pair dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .desc_valid(desc_valid), .desc_entry(desc_entry), .desc_notify(desc_notify),
    .desc_pop(desc_pop), .rpt_push(rpt_push), .rpt_entry(rpt_entry)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mk_desc(input int i);
    logic [31:0] fl;
    fl = (i % 2 == 0) ? 32'h0001_0000 : 32'h0000_0003;
    return {fl, 32'h40 + 32'(i), 32'(i), 32'h1000_0000 + 32'(i) * 32'h100};
  endfunction

  function automatic logic [127:0] mk_rpt(input int i);
    return {32'h8000_0000 | 32'(i), 32'h5A5A_0000 + 32'(i), 32'h10 + 32'(i), 32'hC000_0000 + 32'(i)};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic push_desc(input logic [127:0] e);
    for (int k = 0; k < 4; k++) wr(3'd3, e[k*32 +: 32]);
  endtask

  task automatic pop_desc();
    @(negedge clk); desc_pop = 1'b1;
    @(negedge clk); desc_pop = 1'b0;
  endtask

  task automatic push_rpt(input logic [127:0] e);
    @(negedge clk); rpt_push = 1'b1; rpt_entry = e;
    @(negedge clk); rpt_push = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd1, v); check("R1 desc status", 128'(v), 128'h100);
    rd(3'd2, v); check("R1 rpt status", 128'(v), 128'h100);
    check("R1 desc_valid", 128'(desc_valid), 128'h0);
  endtask

  task automatic t_first_desc();
    logic [31:0] v;
    logic [127:0] e;
    e = mk_desc(0);
    for (int k = 0; k < 3; k++) wr(3'd3, e[k*32 +: 32]);
    check("R3 no commit before fourth word", 128'(desc_valid), 128'h0);
    wr(3'd3, e[127:96]);
    check("R3 valid after fourth word", 128'(desc_valid), 128'h1);
    check("R3 entry word order", desc_entry, e);
    check("R7 notify set", 128'(desc_notify), 128'h1);
    rd(3'd1, v); check("R2 status wr=1", 128'(v), 128'h001);
  endtask

  task automatic t_fill_overflow();
    logic [31:0] v;
    for (int i = 1; i < 4; i++) push_desc(mk_desc(i));
    rd(3'd1, v); check("R4 full with equal pointers", 128'(v), 128'h200);
    push_desc({32'h0001_0000, 32'h77, 32'h0, 32'hDEAD_0000});
    rd(3'd1, v); check("R5 overflow sets error", 128'(v), 128'h600);
    check("R5 head kept", desc_entry, mk_desc(0));
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(3'd1, 32'h0000_03FF);
    rd(3'd1, v); check("R10 zero in bit10 keeps error", 128'(v), 128'h600);
    wr(3'd1, 32'h0000_0400);
    rd(3'd1, v); check("R10 write one clears error", 128'(v), 128'h200);
  endtask

  task automatic t_engine_pop();
    logic [31:0] v;
    pop_desc();
    rd(3'd1, v); check("R6 pop advances read slot", 128'(v), 128'h010);
    check("R6 next head", desc_entry, mk_desc(1));
    check("R7 notify clear", 128'(desc_notify), 128'h0);
    for (int i = 0; i < 3; i++) pop_desc();
    rd(3'd1, v); check("R12 read slot wraps to 0", 128'(v), 128'h100);
    check("R6 valid low when empty", 128'(desc_valid), 128'h0);
    pop_desc();
    rd(3'd1, v); check("R6 pop on empty sets error", 128'(v), 128'h500);
    wr(3'd1, 32'h400);
  endtask

  task automatic t_reports();
    logic [31:0] v;
    rd(3'd4, v); check("R9 empty read returns 0", 128'(v), 128'h0);
    rd(3'd2, v); check("R9 empty read sets error", 128'(v), 128'h500);
    wr(3'd2, 32'h400);
    push_rpt(mk_rpt(0));
    push_rpt(mk_rpt(1));
    rd(3'd2, v); check("R4 occupancy 2", 128'(v), 128'h002);
    for (int k = 0; k < 3; k++) begin
      rd(3'd4, v); check("R8 report word", 128'(v), 128'(mk_rpt(0)[k*32 +: 32]));
    end
    rd(3'd2, v); check("R8 no advance before fourth read", 128'(v), 128'h002);
    rd(3'd4, v); check("R8 report flags word", 128'(v), 128'(mk_rpt(0)[127:96]));
    rd(3'd2, v); check("R8 advance on fourth read", 128'(v), 128'h012);
    rd(3'd4, v); check("R8 second report first word", 128'(v), 128'(mk_rpt(1)[31:0]));
    for (int i = 2; i < 5; i++) push_rpt(mk_rpt(i));
    rd(3'd2, v); check("R12 write slot wraps, full", 128'(v), 128'h211);
    push_rpt(mk_rpt(9));
    rd(3'd2, v); check("R9 push on full sets error", 128'(v), 128'h611);
  endtask

  task automatic t_ring_reset();
    logic [31:0] v;
    wr(3'd3, 32'hAAAA_AAAA);
    wr(3'd3, 32'hBBBB_BBBB);
    wr(3'd0, 32'h1);
    rd(3'd1, v); check("R11 desc ring empty", 128'(v), 128'h100);
    rd(3'd2, v); check("R11 rpt ring empty, error kept", 128'(v), 128'h500);
    push_desc(mk_desc(2));
    check("R11 word counter restarted", desc_entry, mk_desc(2));
    rd(3'd1, v); check("R11 push after reset", 128'(v), 128'h001);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    desc_pop = 0; rpt_push = 0; rpt_entry = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_first_desc();
    t_fill_overflow();
    t_w1c();
    t_engine_pop();
    t_reports();
    t_ring_reset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule